// File: doc/BRIEF.md
# Bus-Decoded Configurable GPIO Pin

This block drives one general-purpose pin from an ISA-style I/O bus. It compares the 11 bus address lines with a programmable pin address, and a hit also needs the address-enable line (AEN) low. A small configuration word gives the pin one of several roles. It can stay tri-stated, or act as a latched output written from the bus. It can act as an input read back onto the bus, or as a bidirectional data bit. Its last role is a decoded chip select whose active level and strobe qualification are programmable.

The pin role, chip-select options and pin address come in as static configuration inputs and are registered into a shadow copy on every clock. Reset returns the shadow copy to the tri-stated role. The written output value is held in a flip-flop. The block drives a single data-bus line during qualifying reads and leaves the rest of the bus undriven. It produces the pin value and the pin output enable for an external pad driver.

Top module: `isa_gpio_pin`

## Requirements
- R1: An address hit needs aen_i low and addr_i equal to the registered pin address on all 11 lines. Without a hit, no write, read or chip select takes effect.
- R2: The role comes from cfg_mode_i: 000 off, 001 output, 010 input, 011 bidirectional, any value with bit 2 set is chip select. pin_oe_o is 1 in output, bidirectional and chip-select roles, and 0 in the off and input roles.
- R3: In the output or bidirectional role, a hit with iow_ni low captures data bit 1 (data_i[1]). The latch updates on the clock edge after iow_ni is seen high again, so pin_o shows the value from the next cycle. In these roles pin_o always shows the latch.
- R4: The latch keeps its value through writes made without a hit, writes made in any other role, and idle cycles. It also keeps its value through role changes.
- R5: In the input or bidirectional role, a hit with ior_ni low sets data_oe_o to 8'b0000_0010 and data_o[1] to pin_i. At all other times data_oe_o is 0.
- R6: In the chip-select role, cfg_cs_pol_i=1 drives pin_o high while the select is active, and cfg_cs_pol_i=0 drives it low. When the select is inactive, pin_o holds the opposite level.
- R7: Chip-select qualification is set by {cfg_rd_qual_i, cfg_wr_qual_i}: 00 hit alone, 01 hit with iow_ni low, 10 hit with ior_ni low, 11 hit with either strobe low.
- R8: While rst_ni is low, the latch is cleared to 0 and the registered role is 000. The pin is then undriven and data_oe_o is 0, whatever the configuration inputs are.
- R9: A configuration change takes effect from the first rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 3 | Pin role |
| cfg_cs_pol_i | input | 1 | Chip-select active level (1 = high) |
| cfg_rd_qual_i | input | 1 | Chip select qualified by read strobe |
| cfg_wr_qual_i | input | 1 | Chip select qualified by write strobe |
| cfg_addr_i | input | 11 | Pin I/O address |
| aen_i | input | 1 | Address enable, a hit needs it low |
| addr_i | input | 11 | Bus address |
| ior_ni | input | 1 | Read strobe, active low |
| iow_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Data bus in |
| data_o | output | 8 | Data bus out |
| data_oe_o | output | 8 | Per-bit data bus drive enable |
| pin_i | input | 1 | Pin level sensed |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
The bench moves each address line off the pin address in turn. If any single line is left out of the compare, a chip select shows up where none belongs. It writes with aen_i high, with a missed address and in the input role, then switches back to output mode. A design that captures on a stray strobe shows up at that point as a flipped pin. It checks all four qualifier codes against both strobes and both polarities, which catches swapped qualifier bits or an inverted level. It times the latch update and the configuration register to the exact cycle, and it checks that only bus bit 1 is ever driven.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF  = 2'd0,
    ROLE_OUT  = 2'd1,
    ROLE_IN   = 2'd2,
    ROLE_BIDI = 2'd3
  } data_role_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       cs_pol;
    logic       rd_qual;
    logic       wr_qual;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{mode: 3'b000, cs_pol: 1'b0, rd_qual: 1'b0, wr_qual: 1'b0};

  function automatic logic is_cs(input logic [2:0] mode);
    return mode[2];
  endfunction

  function automatic logic can_write(input logic [2:0] mode);
    return !mode[2] && (mode[1:0] == ROLE_OUT || mode[1:0] == ROLE_BIDI);
  endfunction

  function automatic logic can_read(input logic [2:0] mode);
    return !mode[2] && (mode[1:0] == ROLE_IN || mode[1:0] == ROLE_BIDI);
  endfunction

endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_pin_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  pin_cfg_t       cfg_i,
  input  logic [AW-1:0]  addr_i,
  output pin_cfg_t       cfg_o,
  output logic [AW-1:0]  addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RESET;
      addr_o <= '0;
    end else begin
      cfg_o  <= cfg_i;
      addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int unsigned AW = 11
) (
  input  logic [AW-1:0] bus_addr_i,
  input  logic [AW-1:0] pin_addr_i,
  input  logic          aen_i,
  output logic          hit_o
);

  logic [AW-1:0] bit_eq;

  for (genvar g = 0; g < AW; g++) begin : g_cmp
    assign bit_eq[g] = bus_addr_i[g] ~^ pin_addr_i[g];
  end

  assign hit_o = !aen_i && (&bit_eq);

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_act_i,
  input  logic wr_bit_i,
  output logic out_o
);

  logic pend_q;
  logic wdat_q;
  logic out_q;

  // capture on the trailing edge of the qualifying write strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wdat_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (wr_act_i) begin
      pend_q <= 1'b1;
      wdat_q <= wr_bit_i;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      out_q  <= wdat_q;
    end
  end

  assign out_o = out_q;

  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(out_q));

  p_capture_on_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wr_act_i) |=> (out_q == $past(wdat_q)));

endmodule

// File: rtl/gpio_cs_gen.sv
module gpio_cs_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ior_ni,
  input  logic iow_ni,
  input  logic rd_qual_i,
  input  logic wr_qual_i,
  input  logic pol_i,
  output logic cs_o
);

  logic sel;

  always_comb begin
    unique case ({rd_qual_i, wr_qual_i})
      2'b00:   sel = hit_i;
      2'b01:   sel = hit_i && !iow_ni;
      2'b10:   sel = hit_i && !ior_ni;
      default: sel = hit_i && (!iow_ni || !ior_ni);
    endcase
  end

  assign cs_o = pol_i ? sel : !sel;

  p_cs_needs_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_qual_i || wr_qual_i) && ior_ni && iow_ni) |-> (cs_o == !pol_i));

endmodule

// File: rtl/isa_gpio_pin.sv
module isa_gpio_pin
  import gpio_pin_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter int unsigned DW       = 8,
  parameter int unsigned DATA_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cfg_mode_i,
  input  logic          cfg_cs_pol_i,
  input  logic          cfg_rd_qual_i,
  input  logic          cfg_wr_qual_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic          aen_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ior_ni,
  input  logic          iow_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] data_oe_o,
  input  logic          pin_i,
  output logic          pin_o,
  output logic          pin_oe_o
);

  pin_cfg_t      cfg_d, cfg_q;
  logic [AW-1:0] pin_addr_q;
  logic          hit, wr_act, rd_act, latch_val, cs_val;

  assign cfg_d = '{mode: cfg_mode_i, cs_pol: cfg_cs_pol_i,
                   rd_qual: cfg_rd_qual_i, wr_qual: cfg_wr_qual_i};

  gpio_cfg_reg #(.AW(AW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_d),
    .addr_i (cfg_addr_i),
    .cfg_o  (cfg_q),
    .addr_o (pin_addr_q)
  );

  gpio_addr_dec #(.AW(AW)) u_dec (
    .bus_addr_i (addr_i),
    .pin_addr_i (pin_addr_q),
    .aen_i      (aen_i),
    .hit_o      (hit)
  );

  assign wr_act = hit && !iow_ni && can_write(cfg_q.mode);
  assign rd_act = hit && !ior_ni && can_read(cfg_q.mode);

  gpio_out_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_act_i (wr_act),
    .wr_bit_i (data_i[DATA_BIT]),
    .out_o    (latch_val)
  );

  gpio_cs_gen u_cs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .ior_ni    (ior_ni),
    .iow_ni    (iow_ni),
    .rd_qual_i (cfg_q.rd_qual),
    .wr_qual_i (cfg_q.wr_qual),
    .pol_i     (cfg_q.cs_pol),
    .cs_o      (cs_val)
  );

  for (genvar g = 0; g < DW; g++) begin : g_bus
    if (g == DATA_BIT) begin : g_live
      assign data_o[g]    = rd_act ? pin_i : 1'b0;
      assign data_oe_o[g] = rd_act;
    end else begin : g_idle
      assign data_o[g]    = 1'b0;
      assign data_oe_o[g] = 1'b0;
    end
  end

  always_comb begin
    if (is_cs(cfg_q.mode)) begin
      pin_o    = cs_val;
      pin_oe_o = 1'b1;
    end else begin
      pin_o    = latch_val;
      pin_oe_o = can_write(cfg_q.mode);
    end
  end

  p_hit_needs_aen_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> !hit);

  p_no_drive_off_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == 3'b000 || cfg_q.mode == 3'b010) |-> !pin_oe_o);

  p_bus_drive_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|data_oe_o) |-> (!ior_ni && !aen_i && addr_i == pin_addr_q));

  p_single_bus_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_oe_o));

  p_cs_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode[2] && !hit) |-> (pin_o == !cfg_q.cs_pol));

endmodule

// File: tb/isa_gpio_pin_test.sv
`timescale 1ns/1ps
module isa_gpio_pin_test;

  localparam logic [10:0] PADDR = 11'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        pol = 1'b0, rq = 1'b0, wq = 1'b0;
  logic        aen = 1'b1;
  logic [10:0] addr = '0;
  logic        ior_n = 1'b1, iow_n = 1'b1;
  logic [7:0]  din = '0;
  logic        pin_in = 1'b0;
  logic [7:0]  dout, doe;
  logic        pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  isa_gpio_pin uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode), .cfg_cs_pol_i(pol),
    .cfg_rd_qual_i(rq), .cfg_wr_qual_i(wq), .cfg_addr_i(PADDR),
    .aen_i(aen), .addr_i(addr), .ior_ni(ior_n), .iow_ni(iow_n),
    .data_i(din), .data_o(dout), .data_oe_o(doe), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic pol, rq, wq, aen, match, ior_n, iow_n, pin_in;
    logic e_pin, e_oe, e_doe, e_dat;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'b100,1,0,0,0,1,1,1,0, 1,1,0,0},
    '{3'b100,0,0,0,0,1,1,1,0, 0,1,0,0},
    '{3'b100,1,0,0,1,1,1,1,0, 0,1,0,0},
    '{3'b100,1,0,0,0,0,1,1,0, 0,1,0,0},
    '{3'b100,0,0,0,0,0,1,1,0, 1,1,0,0},
    '{3'b100,1,0,1,0,1,0,1,0, 0,1,0,0},
    '{3'b100,1,0,1,0,1,1,0,0, 1,1,0,0},
    '{3'b100,1,1,0,0,1,0,1,0, 1,1,0,0},
    '{3'b100,1,1,0,0,1,1,0,0, 0,1,0,0},
    '{3'b100,1,1,1,0,1,0,1,0, 1,1,0,0},
    '{3'b100,1,1,1,0,1,1,0,0, 1,1,0,0},
    '{3'b100,1,1,1,0,1,1,1,0, 0,1,0,0},
    '{3'b100,0,1,1,0,1,1,0,0, 0,1,0,0},
    '{3'b111,1,0,0,0,1,1,1,0, 1,1,0,0},
    '{3'b010,0,0,0,0,1,0,1,1, 0,0,1,1},
    '{3'b010,0,0,0,0,1,0,1,0, 0,0,1,0},
    '{3'b011,0,0,0,0,1,0,1,1, 0,1,1,1},
    '{3'b001,0,0,0,0,1,0,1,1, 0,1,0,0},
    '{3'b000,0,0,0,0,1,0,1,1, 0,0,0,0},
    '{3'b010,0,0,0,1,1,0,1,1, 0,0,0,0},
    '{3'b010,0,0,0,0,0,0,1,1, 0,0,0,0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    aen = 1'b1; addr = '0; ior_n = 1'b1; iow_n = 1'b1; din = '0;
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic p, input logic r, input logic w);
    @(negedge clk);
    mode = m; pol = p; rq = r; wq = w;
    bus_idle();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic a, input logic [10:0] ad, input logic [7:0] d);
    @(negedge clk);
    aen = a; addr = ad; din = d; iow_n = 1'b0;
    @(negedge clk);
    iow_n = 1'b1;
    @(negedge clk);
    bus_idle();
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: reset with output role requested on the inputs
    mode = 3'b001;
    repeat (3) @(negedge clk);
    #1;
    check(pin_oe == 1'b0, "R8", "pin_oe in reset", 16'(pin_oe), 16'h0);
    check(doe == 8'h00, "R8", "data_oe in reset", 16'(doe), 16'h0);
    @(negedge clk);
    mode = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);

    // R9: change applied at negedge, visible only after the next rising edge
    mode = 3'b001;
    #1;
    check(pin_oe == 1'b0, "R9", "oe before edge", 16'(pin_oe), 16'h0);
    @(negedge clk); #1;
    check(pin_oe == 1'b1 && pin_out == 1'b0, "R9", "oe/pin after edge",
          {pin_oe, pin_out}, 16'h2);

    // table walk: latch still 0 from reset
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      logic [7:0] e_doe_v;
      bit ok;
      v = VECS[i];
      set_cfg(v.mode, v.pol, v.rq, v.wq);
      aen = v.aen; addr = v.match ? PADDR : (PADDR ^ 11'h001);
      ior_n = v.ior_n; iow_n = v.iow_n; pin_in = v.pin_in; din = 8'h02;
      #1;
      if (v.aen || !v.match) tag = "R1";
      else if (v.mode[2]) tag = (v.rq || v.wq) ? "R7" : "R6";
      else if (!v.ior_n) tag = "R5";
      else tag = "R2";
      e_doe_v = v.e_doe ? 8'h02 : 8'h00;
      ok = (pin_oe == v.e_oe) && (doe == e_doe_v) &&
           (!v.e_oe || pin_out == v.e_pin) && (!v.e_doe || dout[1] == v.e_dat);
      check(ok, tag, $sformatf("vector %0d oe/pin/doe/dat", i),
            {pin_oe, pin_out, doe, dout[1]}, {v.e_oe, v.e_pin, e_doe_v, v.e_dat});
      @(negedge clk);
      bus_idle();
    end

    // R1: every single address line mismatch blocks the chip select
    set_cfg(3'b100, 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < 11; b++) begin
      aen = 1'b0; addr = PADDR ^ (11'h001 << b);
      #1;
      check(pin_out == 1'b0, "R1", $sformatf("addr bit %0d off", b), 16'(pin_out), 16'h0);
      @(negedge clk);
    end
    bus_idle();

    // R3: write timing and hold
    set_cfg(3'b001, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    aen = 1'b0; addr = PADDR; din = 8'h02; iow_n = 1'b0;
    @(negedge clk); #1;
    check(pin_out == 1'b0, "R3", "no update while strobe low", 16'(pin_out), 16'h0);
    @(negedge clk);
    iow_n = 1'b1;
    #1;
    check(pin_out == 1'b0, "R3", "no update before edge", 16'(pin_out), 16'h0);
    @(negedge clk); #1;
    check(pin_out == 1'b1, "R3", "update after release", 16'(pin_out), 16'h1);
    bus_idle();
    repeat (5) @(negedge clk);
    #1;
    check(pin_out == 1'b1, "R4", "hold over idle", 16'(pin_out), 16'h1);
    bus_write(1'b0, PADDR, 8'hFD);
    check(pin_out == 1'b0, "R3", "bit1 only captured", 16'(pin_out), 16'h0);

    // R4: stray writes leave the latch alone
    bus_write(1'b1, PADDR, 8'h02);
    check(pin_out == 1'b0, "R4", "write with aen high", 16'(pin_out), 16'h0);
    bus_write(1'b0, PADDR ^ 11'h400, 8'h02);
    check(pin_out == 1'b0, "R4", "write to other addr", 16'(pin_out), 16'h0);
    set_cfg(3'b010, 1'b0, 1'b0, 1'b0);
    bus_write(1'b0, PADDR, 8'h02);
    set_cfg(3'b001, 1'b0, 1'b0, 1'b0);
    #1;
    check(pin_out == 1'b0, "R4", "write in input role", 16'(pin_out), 16'h0);

    // R3/R5: bidirectional write then read of pin level
    set_cfg(3'b011, 1'b0, 1'b0, 1'b0);
    bus_write(1'b0, PADDR, 8'h02);
    check(pin_out == 1'b1 && pin_oe == 1'b1, "R3", "bidir write", {pin_oe, pin_out}, 16'h3);
    @(negedge clk);
    aen = 1'b0; addr = PADDR; ior_n = 1'b0; pin_in = 1'b0;
    #1;
    check(doe == 8'h02 && dout[1] == 1'b0, "R5", "bidir read pin", {doe, dout}, 16'h0200);
    @(negedge clk);
    bus_idle();
    #1;
    check(doe == 8'h00, "R5", "bus released", 16'(doe), 16'h0);

    // R8: reset mid-run clears the latch
    rst_n = 1'b0;
    #1;
    check(pin_oe == 1'b0, "R8", "reset tri-states pin", 16'(pin_oe), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mode = 3'b001;
    @(negedge clk); #1;
    check(pin_out == 1'b0 && pin_oe == 1'b1, "R8", "latch cleared", {pin_oe, pin_out}, 16'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule